// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches recent virtual-to-physical page mappings. A lookup presents a virtual address. The page-number part is compared against every stored entry at the same time. When an entry matches, the block returns the stored frame number joined to the untouched page offset in the same cycle. When no entry matches, the block raises a miss. Logic outside the block then walks the page table and writes the result back through the fill port. A single flush input drops every mapping at once, for use on a context switch.

A fill first reuses an entry that already holds the same page. Otherwise it takes the lowest-numbered free entry. When every entry is valid, it replaces entries in round-robin order. Two free-running counters tally hits and misses so that the hit ratio can be measured.

Top module: `tlb_assoc`

## Requirements
- R1: After reset every entry is invalid, both counters read zero and any lookup misses.
- R2: A valid lookup whose page number matches a valid entry asserts lkp_hit_o in the same cycle. lkp_paddr_o then equals {stored frame, lookup offset}, with the offset in the low OFS_W bits.
- R3: A valid lookup that matches no valid entry asserts lkp_miss_o, deasserts lkp_hit_o and drives lkp_paddr_o to zero.
- R4: A fill of a page number not present is written to the lowest-indexed invalid entry. It becomes visible from the cycle after the fill.
- R5: A fill of a page number already held by a valid entry overwrites the frame of that entry. No second copy is created, and at most one entry ever matches a page number.
- R6: When all entries are valid, a fill of a new page number replaces the entry under a round-robin pointer. The pointer starts at entry 0 and advances by one per such replacement, wrapping after DEPTH-1.
- R7: flush_i invalidates every entry at the next edge and returns the round-robin pointer to entry 0.
- R8: When flush_i and fill_valid_i are high in the same cycle, the fill is dropped.
- R9: Each valid lookup increments exactly one of hit_count_o and miss_count_o by one at the following edge, according to its hit or miss result.
- R10: A lookup in the same cycle as a fill or flush is answered from the contents held before that edge.
- R11: With lkp_valid_i low, lkp_hit_o, lkp_miss_o and lkp_paddr_o are zero and neither counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_vaddr_i | input | VPN_W+OFS_W | Virtual address to translate |
| lkp_hit_o | output | 1 | Lookup matched an entry |
| lkp_miss_o | output | 1 | Lookup matched no entry; page-table walk needed |
| lkp_paddr_o | output | PFN_W+OFS_W | Translated physical address, zero unless hit |
| fill_valid_i | input | 1 | Write a mapping |
| fill_vpn_i | input | VPN_W | Page number of the mapping |
| fill_pfn_i | input | PFN_W | Frame number of the mapping |
| flush_i | input | 1 | Invalidate all entries |
| hit_count_o | output | CNT_W | Number of lookup hits |
| miss_count_o | output | CNT_W | Number of lookup misses |

## Verification
Some rules are checked on every cycle by the assertions. These are: the exclusivity and gating of hit and miss, the pass-through of the page offset, the at-most-one-match property of the entry array, the visibility of a fill on the next cycle, the blank result after a flush, and the one-step behaviour of the counters. Replacement order can only be shown by the bench scenarios. This covers lowest-free placement, reuse of an existing page, round-robin eviction and its restart after a flush, and the fill being dropped under a simultaneous flush. These scenarios fill the array to capacity and then probe which pages survive.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SAME = 2'd1,
    SRC_FREE = 2'd2,
    SRC_RR   = 2'd3
  } fill_src_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int DEPTH = 16,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_all_i,
  input  logic                     wr_en_i,
  input  logic [$clog2(DEPTH)-1:0] wr_idx_i,
  input  logic [VPN_W-1:0]         wr_vpn_i,
  input  logic [PFN_W-1:0]         wr_pfn_i,
  input  logic [VPN_W-1:0]         lkp_vpn_i,
  output logic [DEPTH-1:0]         lkp_match_o,
  output logic [PFN_W-1:0]         lkp_pfn_o,
  output logic [DEPTH-1:0]         wr_match_o,
  output logic [DEPTH-1:0]         valid_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0] valid_q;
  logic [VPN_W-1:0] vpn_q [DEPTH];
  logic [PFN_W-1:0] pfn_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        vpn_q[i] <= '0;
        pfn_q[i] <= '0;
      end
    end else if (clr_all_i) begin
      valid_q <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_idx_i == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          vpn_q[i]   <= wr_vpn_i;
          pfn_q[i]   <= wr_pfn_i;
        end
      end
    end
  end

  // two compare ports: one for lookups, one for fill dedup
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign lkp_match_o[g] = valid_q[g] && (vpn_q[g] == lkp_vpn_i);
    assign wr_match_o[g]  = valid_q[g] && (vpn_q[g] == wr_vpn_i);
  end

  // one-hot match, so OR-combining is a mux
  always_comb begin
    lkp_pfn_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (lkp_match_o[i]) lkp_pfn_o = lkp_pfn_o | pfn_q[i];
    end
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     fill_req_i,
  input  logic                     flush_i,
  input  logic [DEPTH-1:0]         valid_i,
  input  logic [DEPTH-1:0]         same_i,
  output logic                     wr_en_o,
  output logic [$clog2(DEPTH)-1:0] wr_idx_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] rr_q, same_idx, free_idx;
  logic             any_same, any_free;
  fill_src_e        src;

  always_comb begin
    same_idx = '0;
    free_idx = '0;
    any_same = 1'b0;
    any_free = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (same_i[i]) begin
        same_idx = IDX_W'(i);
        any_same = 1'b1;
      end
      if (!valid_i[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  always_comb begin
    if (!fill_req_i || flush_i) src = SRC_NONE;
    else if (any_same)          src = SRC_SAME;
    else if (any_free)          src = SRC_FREE;
    else                        src = SRC_RR;
  end

  always_comb begin
    unique case (src)
      SRC_SAME: wr_idx_o = same_idx;
      SRC_FREE: wr_idx_o = free_idx;
      default:  wr_idx_o = rr_q;
    endcase
  end

  assign wr_en_o = (src != SRC_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rr_q <= '0;
    else if (flush_i)        rr_q <= '0;
    else if (src == SRC_RR)  rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/tlb_stats.sv
module tlb_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lkp_valid_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] hit_count_o,
  output logic [CNT_W-1:0] miss_count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_count_o  <= '0;
      miss_count_o <= '0;
    end else if (lkp_valid_i) begin
      if (hit_i) hit_count_o  <= hit_count_o + 1'b1;
      else       miss_count_o <= miss_count_o + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc #(
  parameter int DEPTH = 16,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int OFS_W = 12,
  parameter int CNT_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   lkp_valid_i,
  input  logic [VPN_W+OFS_W-1:0] lkp_vaddr_i,
  output logic                   lkp_hit_o,
  output logic                   lkp_miss_o,
  output logic [PFN_W+OFS_W-1:0] lkp_paddr_o,
  input  logic                   fill_valid_i,
  input  logic [VPN_W-1:0]       fill_vpn_i,
  input  logic [PFN_W-1:0]       fill_pfn_i,
  input  logic                   flush_i,
  output logic [CNT_W-1:0]       hit_count_o,
  output logic [CNT_W-1:0]       miss_count_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int VA_W  = VPN_W + OFS_W;

  logic [VPN_W-1:0] lkp_vpn;
  logic [OFS_W-1:0] lkp_ofs;
  logic [DEPTH-1:0] lkp_match, wr_match, valid;
  logic [PFN_W-1:0] lkp_pfn;
  logic             wr_en, any_match;
  logic [IDX_W-1:0] wr_idx;

  assign lkp_vpn = lkp_vaddr_i[VA_W-1:OFS_W];
  assign lkp_ofs = lkp_vaddr_i[OFS_W-1:0];

  tlb_cam #(.DEPTH(DEPTH), .VPN_W(VPN_W), .PFN_W(PFN_W)) i_cam (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_all_i   (flush_i),
    .wr_en_i     (wr_en),
    .wr_idx_i    (wr_idx),
    .wr_vpn_i    (fill_vpn_i),
    .wr_pfn_i    (fill_pfn_i),
    .lkp_vpn_i   (lkp_vpn),
    .lkp_match_o (lkp_match),
    .lkp_pfn_o   (lkp_pfn),
    .wr_match_o  (wr_match),
    .valid_o     (valid)
  );

  tlb_victim #(.DEPTH(DEPTH)) i_victim (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fill_req_i (fill_valid_i),
    .flush_i    (flush_i),
    .valid_i    (valid),
    .same_i     (wr_match),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx)
  );

  assign any_match   = |lkp_match;
  assign lkp_hit_o   = lkp_valid_i && any_match;
  assign lkp_miss_o  = lkp_valid_i && !any_match;
  assign lkp_paddr_o = lkp_hit_o ? {lkp_pfn, lkp_ofs} : '0;

  tlb_stats #(.CNT_W(CNT_W)) i_stats (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lkp_valid_i  (lkp_valid_i),
    .hit_i        (any_match),
    .hit_count_o  (hit_count_o),
    .miss_count_o (miss_count_o)
  );
endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk #(
  parameter int DEPTH = 16,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int OFS_W = 12,
  parameter int CNT_W = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   lkp_valid_i,
  input logic [VPN_W+OFS_W-1:0] lkp_vaddr_i,
  input logic                   lkp_hit_o,
  input logic                   lkp_miss_o,
  input logic [PFN_W+OFS_W-1:0] lkp_paddr_o,
  input logic                   fill_valid_i,
  input logic [VPN_W-1:0]       fill_vpn_i,
  input logic [PFN_W-1:0]       fill_pfn_i,
  input logic                   flush_i,
  input logic [CNT_W-1:0]       hit_count_o,
  input logic [CNT_W-1:0]       miss_count_o,
  input logic [DEPTH-1:0]       match_vec
);
  localparam int VA_W = VPN_W + OFS_W;
  localparam int PA_W = PFN_W + OFS_W;

  // R11
  hit_miss_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_valid_i |-> (!lkp_hit_o && !lkp_miss_o && lkp_paddr_o == '0));

  // R3
  hit_miss_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i |-> (lkp_hit_o != lkp_miss_o));

  // R2
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_hit_o |-> (lkp_paddr_o[OFS_W-1:0] == lkp_vaddr_i[OFS_W-1:0]));

  // R5
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_vec));

  // R4
  fill_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !flush_i) |=>
      (!(lkp_valid_i && lkp_vaddr_i[VA_W-1:OFS_W] == $past(fill_vpn_i)) ||
       (lkp_hit_o && lkp_paddr_o[PA_W-1:OFS_W] == $past(fill_pfn_i))));

  // R7
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !lkp_hit_o);

  // R9
  hit_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_hit_o |=> (hit_count_o == CNT_W'($past(hit_count_o) + 1'b1)) && $stable(miss_count_o));

  // R9
  miss_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_miss_o |=> (miss_count_o == CNT_W'($past(miss_count_o) + 1'b1)) && $stable(hit_count_o));

  // R11
  idle_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_valid_i |=> $stable(hit_count_o) && $stable(miss_count_o));
endmodule

bind tlb_assoc tlb_assoc_chk #(
  .DEPTH(DEPTH), .VPN_W(VPN_W), .PFN_W(PFN_W), .OFS_W(OFS_W), .CNT_W(CNT_W)
) i_tlb_assoc_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lkp_valid_i  (lkp_valid_i),
  .lkp_vaddr_i  (lkp_vaddr_i),
  .lkp_hit_o    (lkp_hit_o),
  .lkp_miss_o   (lkp_miss_o),
  .lkp_paddr_o  (lkp_paddr_o),
  .fill_valid_i (fill_valid_i),
  .fill_vpn_i   (fill_vpn_i),
  .fill_pfn_i   (fill_pfn_i),
  .flush_i      (flush_i),
  .hit_count_o  (hit_count_o),
  .miss_count_o (miss_count_o),
  .match_vec    (lkp_match)
);

// File: tb/test_tlb_assoc.sv
`timescale 1ns/1ps
module test_tlb_assoc;
  localparam int DEPTH = 16;
  localparam int VPN_W = 20;
  localparam int PFN_W = 20;
  localparam int OFS_W = 12;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic lkp_valid_i = 1'b0;
  logic [VPN_W+OFS_W-1:0] lkp_vaddr_i = '0;
  logic lkp_hit_o, lkp_miss_o;
  logic [PFN_W+OFS_W-1:0] lkp_paddr_o;
  logic fill_valid_i = 1'b0;
  logic [VPN_W-1:0] fill_vpn_i = '0;
  logic [PFN_W-1:0] fill_pfn_i = '0;
  logic flush_i = 1'b0;
  logic [CNT_W-1:0] hit_count_o, miss_count_o;

  always #10 clk = ~clk;

  tlb_assoc #(.DEPTH(DEPTH), .VPN_W(VPN_W), .PFN_W(PFN_W), .OFS_W(OFS_W), .CNT_W(CNT_W)) i_tlb_assoc (
    .clk_i(clk), .rst_ni(rst_ni), .lkp_valid_i(lkp_valid_i), .lkp_vaddr_i(lkp_vaddr_i),
    .lkp_hit_o(lkp_hit_o), .lkp_miss_o(lkp_miss_o), .lkp_paddr_o(lkp_paddr_o),
    .fill_valid_i(fill_valid_i), .fill_vpn_i(fill_vpn_i), .fill_pfn_i(fill_pfn_i),
    .flush_i(flush_i), .hit_count_o(hit_count_o), .miss_count_o(miss_count_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model
  bit               m_val [DEPTH];
  logic [VPN_W-1:0] m_vpn [DEPTH];
  logic [PFN_W-1:0] m_pfn [DEPTH];
  int               m_rr = 0;
  int               m_hits = 0;
  int               m_miss = 0;

  function automatic int m_find(input logic [VPN_W-1:0] v);
    for (int i = 0; i < DEPTH; i++) if (m_val[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  function automatic int m_free();
    for (int i = 0; i < DEPTH; i++) if (!m_val[i]) return i;
    return -1;
  endfunction

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit lv, input logic [VPN_W-1:0] lvpn, input logic [OFS_W-1:0] lofs,
                      input bit fv, input logic [VPN_W-1:0] fvpn, input logic [PFN_W-1:0] fpfn,
                      input bit fl, input string tag);
    int idx;
    bit eh;
    logic [PFN_W+OFS_W-1:0] ep;
    @(negedge clk);
    lkp_valid_i  = lv;
    lkp_vaddr_i  = {lvpn, lofs};
    fill_valid_i = fv;
    fill_vpn_i   = fvpn;
    fill_pfn_i   = fpfn;
    flush_i      = fl;
    #5;
    idx = m_find(lvpn);
    eh  = lv && (idx >= 0);
    ep  = eh ? {m_pfn[idx], lofs} : '0;
    check(tag, "hit", lkp_hit_o, eh);
    check(tag, "miss", lkp_miss_o, lv && !eh);
    check(tag, "paddr", lkp_paddr_o, ep);
    check("R9", "hit_count", hit_count_o, m_hits % (1 << CNT_W));
    check("R9", "miss_count", miss_count_o, m_miss % (1 << CNT_W));
    // state after the coming edge
    if (lv) begin
      if (eh) m_hits++;
      else    m_miss++;
    end
    if (fl) begin
      for (int i = 0; i < DEPTH; i++) m_val[i] = 0;
      m_rr = 0;
    end else if (fv) begin
      idx = m_find(fvpn);
      if (idx < 0) idx = m_free();
      if (idx < 0) begin
        idx  = m_rr;
        m_rr = (m_rr + 1) % DEPTH;
      end
      m_val[idx] = 1;
      m_vpn[idx] = fvpn;
      m_pfn[idx] = fpfn;
    end
  endtask

  task automatic look(input logic [VPN_W-1:0] v, input string tag);
    step(1, v, 12'h5A5, 0, '0, '0, 0, tag);
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [PFN_W-1:0] p, input string tag);
    step(0, '0, '0, 1, v, p, 0, tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h7C1B));
    for (int i = 0; i < DEPTH; i++) begin
      m_val[i] = 0;
      m_vpn[i] = '0;
      m_pfn[i] = '0;
    end
    repeat (3) @(negedge clk);
    check("R1", "hit_count_rst", hit_count_o, 0);
    check("R1", "miss_count_rst", miss_count_o, 0);
    rst_ni = 1'b1;

    // R1: empty after reset
    look(20'h10000, "R1");
    look(20'h00000, "R1");
    // R10: lookup during the fill cycle sees old contents
    step(1, 20'h10000, 12'h123, 1, 20'h10000, 20'hABC00, 0, "R10");
    // R2: hit with offset pass-through
    step(1, 20'h10000, 12'hFFF, 0, '0, '0, 0, "R2");
    fill(20'h10001, 20'hABC01, "R4");
    look(20'h10001, "R2");
    look(20'h10002, "R3");
    // R11: idle lookup port
    step(0, 20'h10001, 12'h001, 0, '0, '0, 0, "R11");
    step(0, 20'h10000, 12'h001, 0, '0, '0, 0, "R11");
    // R5: refill existing page updates frame, no extra entry
    fill(20'h10000, 20'h12345, "R5");
    look(20'h10000, "R5");
    for (int i = 2; i < DEPTH; i++) fill(20'h20000 + i, 20'h30000 + i, "R4");
    for (int i = 2; i < DEPTH; i++) look(20'h20000 + i, "R4");
    look(20'h10000, "R5");
    look(20'h10001, "R5");
    // R6: full array, eviction order 0,1,2
    fill(20'h40000, 20'h50000, "R6");
    look(20'h10000, "R6");
    look(20'h10001, "R6");
    look(20'h40000, "R6");
    fill(20'h40001, 20'h50001, "R6");
    look(20'h10001, "R6");
    look(20'h20002, "R6");
    // R10: lookup during the flush cycle still hits
    step(1, 20'h40000, 12'h0AA, 0, '0, '0, 1, "R10");
    // R7: everything gone
    look(20'h40000, "R7");
    look(20'h20005, "R7");
    // R8: flush wins over fill
    step(0, '0, '0, 1, 20'h60000, 20'h70000, 1, "R8");
    look(20'h60000, "R8");
    // R7: pointer restarts at 0 after flush
    for (int i = 0; i <= DEPTH; i++) fill(20'h80000 + i, 20'h90000 + i, "R7");
    look(20'h80000, "R7");
    look(20'h80001, "R7");
    look(20'h80000 + DEPTH, "R7");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [VPN_W-1:0] rv, fvv;
      rv  = 20'hC0000 + ($urandom % 24);
      fvv = 20'hC0000 + ($urandom % 24);
      step(($urandom % 4) != 0, rv, 12'($urandom),
           ($urandom % 3) == 0, fvv, 20'($urandom),
           ($urandom % 97) == 0, "R2");
    end

    step(0, '0, '0, 0, '0, '0, 0, "R11");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule